// File: doc/BRIEF.md
# Chained Bit-Slice Magnitude Comparator

This block compares two unsigned operands of equal width using no clock. It is built from a row of identical one-bit cells. Each cell receives one bit from each operand. It also receives two status flags from the cell before it: "all higher bits matched" and "already found larger". It passes updated flags on to the next cell. The cell that handles the most significant bit starts the row, so a difference in a higher bit settles the result before the lower bits are looked at.

The flags leaving the last cell are the block's outputs. When the match flag is high, the operands are identical. When the larger flag is high, the first operand exceeds the second. When both flags are low, the first operand is the smaller one, so no third output is needed. The first cell is seeded with match high and larger low. The operand width is a parameter and defaults to four bits.

Top module: `mag_cmp_chain`

## Requirements
- R1: `eq_o` is 1 exactly when `a_i` equals `b_i`.
- R2: `gt_o` is 1 exactly when `a_i`, read as unsigned, is larger than `b_i`.
- R3: `a_i` smaller than `b_i` is encoded as `eq_o` = 0 and `gt_o` = 0.
- R4: `eq_o` and `gt_o` are never 1 at the same time.
- R5: The most significant differing bit alone decides the result. Every lower bit has no effect on the outputs once a higher bit differs.
- R6: The outputs follow an operand change within the same cycle. No clock edge lies between the inputs and the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| eq_o | output | 1 | Operands identical |
| gt_o | output | 1 | First operand larger; both flags low means smaller |

## Verification
The hardest case to reach is a higher bit that decides the result while the lower bits point the other way. A cell that wrongly keeps looking at lower bits after a difference only shows its fault in this case. With eight input bits, the bench walks through all 256 operand pairs, so every such case occurs. It also adds directed pairs in which the lower bits are all set against the answer. To test that no clock is involved, some operands are changed between clock edges and the outputs are sampled shortly after the change.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  typedef struct packed {
    logic eq;  // all higher bits matched
    logic gt;  // a already known larger
  } cmp_flag_t;

  localparam cmp_flag_t CMP_SEED = '{eq: 1'b1, gt: 1'b0};

endpackage

// File: rtl/cmp_slice.sv
module cmp_slice
  import mag_cmp_pkg::*;
(
  input  logic      a_bit_i,
  input  logic      b_bit_i,
  input  cmp_flag_t flag_i,
  output cmp_flag_t flag_o
);

  logic bit_match;

  assign bit_match = ~(a_bit_i ^ b_bit_i);

  always_comb begin
    if (flag_i.eq) begin
      flag_o.eq = bit_match;
      flag_o.gt = a_bit_i & ~b_bit_i;
    end else begin
      flag_o.eq = 1'b0;
      flag_o.gt = flag_i.gt;
    end
  end

endmodule

// File: rtl/cmp_cascade.sv
module cmp_cascade
  import mag_cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  cmp_flag_t        seed_i,
  output cmp_flag_t        flag_o
);

  cmp_flag_t link [WIDTH+1];

  assign link[0] = seed_i;

  // stage k handles bit WIDTH-1-k: MSB first
  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    localparam int unsigned BIT = WIDTH - 1 - k;
    cmp_slice i_slice (
      .a_bit_i (a_i[BIT]),
      .b_bit_i (b_i[BIT]),
      .flag_i  (link[k]),
      .flag_o  (link[k+1])
    );
  end

  assign flag_o = link[WIDTH];

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             eq_o,
  output logic             gt_o
);

  cmp_flag_t result;

  cmp_cascade #(.WIDTH(WIDTH)) i_cascade (
    .a_i    (a_i),
    .b_i    (b_i),
    .seed_i (CMP_SEED),
    .flag_o (result)
  );

  assign eq_o = result.eq;
  assign gt_o = result.gt;

endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
  parameter int unsigned WIDTH = 4
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             eq_o,
  input logic             gt_o
);

  logic known;
  assign known = !$isunknown({a_i, b_i, eq_o, gt_o});

  always_comb begin
    if (known) begin
      a_r1_equal: assert (eq_o == (a_i == b_i))
        else $error("a_r1_equal");
      a_r2_greater: assert (gt_o == (a_i > b_i))
        else $error("a_r2_greater");
      a_r3_less: assert ((!eq_o && !gt_o) == (a_i < b_i))
        else $error("a_r3_less");
      a_r4_exclusive: assert (!(eq_o && gt_o))
        else $error("a_r4_exclusive");
    end
  end

endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WIDTH(WIDTH)) i_chk (
  .a_i  (a_i),
  .b_i  (b_i),
  .eq_o (eq_o),
  .gt_o (gt_o)
);

// File: tb/test_mag_cmp_chain.sv
module test_mag_cmp_chain;

  localparam int unsigned WIDTH   = 4;
  localparam time         CLK_PER = 10ns;
  localparam int          N       = 1 << WIDTH;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [WIDTH-1:0] a, b;
  logic             eq, gt;
  int               n_run = 0, n_fail = 0;
  bit               done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  mag_cmp_chain #(.WIDTH(WIDTH)) i_mag_cmp_chain (
    .a_i(a), .b_i(b), .eq_o(eq), .gt_o(gt)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d actual=%b expected=%b", req, a, b, act, exp);
    end
  endtask

  // behavioural reference on integers
  task automatic check_all();
    int ia = int'(a);
    int ib = int'(b);
    check("R1", eq, ia == ib);
    check("R2", gt, ia > ib);
    check("R3", !eq && !gt, ia < ib);
    check("R4", eq && gt, 1'b0);
  endtask

  task automatic apply(input int va, input int vb);
    @(posedge clk);
    a = va[WIDTH-1:0];
    b = vb[WIDTH-1:0];
    @(negedge clk);
    check_all();
  endtask

  initial begin
    a = '0;
    b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", eq, 1'b1);  // reset state: zero operands
    check("R2", gt, 1'b0);
    rst_n = 1'b1;

    // exhaustive sweep
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        apply(i, j);

    // R5: MSB decides against all lower bits
    apply(4'b1000, 4'b0111);
    check("R5", gt, 1'b1);
    apply(4'b0111, 4'b1000);
    check("R5", eq | gt, 1'b0);
    apply(4'b0100, 4'b0011);
    check("R5", gt, 1'b1);
    apply(4'b1011, 4'b1100);
    check("R5", eq | gt, 1'b0);

    // R6: change between edges, sample 1ns later
    @(negedge clk);
    #(CLK_PER/4);
    a = 4'd9; b = 4'd3;
    #1ns;
    check("R6", gt, 1'b1);
    b = 4'd9;
    #1ns;
    check("R6", eq, 1'b1);
    a = 4'd2;
    #1ns;
    check("R6", eq | gt, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule